// File: doc/BRIEF.md
# Three-Lane Multi-Format Audio Serial Receiver

This block takes serial PCM audio on three data lanes. The lanes share a single bit clock and a single word clock. The block turns the stream into six parallel two's-complement samples, one left/right pair per lane. The bit clock and the word clock are synchronous to the system clock. They are not used as clocks. The block resynchronises them together with the data lanes, detects edges on them, and samples every lane in the system clock cycle that follows a detected rising bit-clock edge.

A 3-bit format code selects how each word sits inside its half-frame. The choices are right-justified, left-justified, and the common "one bit late, left on low" framing. After reset the code is right-justified 24-bit. A frame may carry 48 or 64 bit-clock periods. When a frame's right word is complete, all six outputs update in the same cycle as a one-cycle valid strobe. A new format code is adopted only at a word-clock edge. A frame that spans the change is dropped.

Top module: `tri_lane_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is low and every bit of `pcm_o` is zero, until the first frame completes.
- R2: Lane data is sampled only at rising bit-clock edges. `valid_o` is a one-cycle pulse, raised once per completed frame. `pcm_o` changes only in a cycle where `valid_o` is high.
- R3: Lane k (k = 0, 1, 2) left word appears on `pcm_o[48k+23:48k]` and its right word on `pcm_o[48k+47:48k+24]`. In one-based terms, channel c occupies `pcm_o[24c-1:24c-24]`, so lane 0 drives channels 1/2, lane 1 drives channels 3/4 and lane 2 drives channels 5/6.
- R4: Format code 0 (right-justified, reset default). Word clock high marks the left half. Each word is the last 24 bits received before the word-clock edge that ends its half, MSB first. Earlier bits in a longer half are discarded.
- R5: Format code 1 (left-justified). Word clock high marks the left half. The MSB is the bit sampled at the first rising bit-clock edge at which the word clock shows the new level. The following 23 bits complete the word, and any bits after them are ignored.
- R6: Format code 2 (delayed framing). Word clock low marks the left half. The MSB is the bit one bit-clock after the first edge of the half. At 48 bits per frame, the LSB is the first bit of the next half.
- R7: All formats work with 24 or 32 bit-clock periods per half-frame, which is 48 or 64 per frame.
- R8: Format codes 3 to 7 behave exactly like code 0.
- R9: A format code change is adopted at the next word-clock edge. A frame whose halves straddle that edge is never output. Frames that follow are decoded in the new format.
- R10: Output requires a left word followed by a right word, both complete and both in the same format. A lone right word after reset or after a format change produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| word_clk_i | input | 1 | Left/right word clock, toggles once per half-frame |
| sdata_i | input | 3 | Serial data, one bit per lane |
| fmt_i | input | 3 | Framing code: 0 right-justified, 1 left-justified, 2 delayed, others as 0 |
| pcm_o | output | 144 | Six 24-bit samples, channel c in bits [24c-1:24c-24] |
| valid_o | output | 1 | One-cycle strobe, all six samples updated |

## Verification
The hardest case to reach is a format change that lands inside a frame, so that one half would be decoded in the old framing and the other in the new. The stimulus rewrites the format code halfway through a left half. It then checks that the frame is missing from the output and that the next frame under the new code decodes correctly. Sections in different formats are chained with no reset between them, so every format boundary also passes through the discard path. The 48-bit delayed framing is covered too: its LSB crosses into the following half, which includes the tail after the last frame.

// File: rtl/tlrx_pkg.sv
package tlrx_pkg;

   localparam int unsigned FMT_W = 3;

   localparam logic [FMT_W-1:0] FMT_RJ  = 3'd0;
   localparam logic [FMT_W-1:0] FMT_LJ  = 3'd1;
   localparam logic [FMT_W-1:0] FMT_DLY = 3'd2;

   typedef enum logic [1:0] {
      MODE_RJ,
      MODE_LJ,
      MODE_DLY
   } frame_mode_e;

   // unknown codes fall back to right-justified framing
   function automatic frame_mode_e decode_fmt(input logic [FMT_W-1:0] code);
      case (code)
         FMT_LJ:  return MODE_LJ;
         FMT_DLY: return MODE_DLY;
         default: return MODE_RJ;
      endcase
   endfunction

endpackage

// File: rtl/tlrx_sync.sv
module tlrx_sync #(
   parameter int unsigned N      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] din_i,
   output logic [N-1:0] dout_o
);

   logic [STAGES-1:0][N-1:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[0] <= '0;
      else         pipe_q[0] <= din_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pipe_q[s] <= '0;
         else         pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign dout_o = pipe_q[STAGES-1];

endmodule

// File: rtl/tlrx_framer.sv
module tlrx_framer
   import tlrx_pkg::*;
#(
   parameter int unsigned W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bclk_s_i,
   input  logic             wclk_s_i,
   input  logic [FMT_W-1:0] fmt_i,
   output logic             shift_o,
   output logic             take_pre_o,
   output logic             done_o,
   output logic             done_left_o,
   output logic             publish_o
);

   localparam int unsigned     CW   = $clog2(W + 1);
   localparam logic [CW-1:0]   LAST = CW'(W - 1);
   localparam logic [CW-1:0]   FULL = CW'(W);

   logic             bprev_q, wprev_q, armed_q, left_ok_q;
   logic [FMT_W-1:0] fmt_q;
   logic [CW-1:0]    cnt_q, cnt_n;
   logic             rise, wedge, chg;
   frame_mode_e      mode_q, mode_new, mode_start;

   assign rise     = bclk_s_i & ~bprev_q;
   assign wedge    = wclk_s_i ^ wprev_q;
   assign chg      = wedge & (fmt_i != fmt_q);
   assign mode_q   = decode_fmt(fmt_q);
   assign mode_new = decode_fmt(fmt_i);

   always_comb begin
      shift_o     = 1'b0;
      take_pre_o  = 1'b0;
      done_o      = 1'b0;
      done_left_o = 1'b0;
      cnt_n       = cnt_q;
      mode_start  = chg ? mode_new : mode_q;
      if (rise) begin
         if (wedge) begin
            // close the half that just ended, unless the format is switching
            if (armed_q && !chg) begin
               case (mode_q)
                  MODE_RJ: begin
                     done_o      = 1'b1;
                     take_pre_o  = 1'b1;
                     done_left_o = wprev_q;
                  end
                  MODE_DLY: begin
                     if (cnt_q == LAST) begin
                        done_o      = 1'b1;
                        shift_o     = 1'b1;
                        done_left_o = ~wprev_q;
                     end
                  end
                  default: ;
               endcase
            end
            // open the new half in the (possibly new) format
            case (mode_start)
               MODE_LJ: begin
                  shift_o = 1'b1;
                  cnt_n   = CW'(1);
               end
               MODE_DLY: cnt_n = '0;
               default: begin
                  shift_o = 1'b1;
                  cnt_n   = FULL;
               end
            endcase
         end else begin
            case (mode_q)
               MODE_RJ: shift_o = 1'b1;
               default: begin
                  if (cnt_q < FULL) begin
                     shift_o = 1'b1;
                     cnt_n   = cnt_q + CW'(1);
                     if (cnt_q == LAST) begin
                        done_o      = 1'b1;
                        done_left_o = (mode_q == MODE_LJ) ? wclk_s_i : ~wclk_s_i;
                     end
                  end
               end
            endcase
         end
      end
   end

   assign publish_o = done_o & ~done_left_o & left_ok_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bprev_q   <= 1'b0;
         wprev_q   <= 1'b0;
         armed_q   <= 1'b0;
         left_ok_q <= 1'b0;
         fmt_q     <= FMT_RJ;
         cnt_q     <= FULL;
      end else begin
         bprev_q <= bclk_s_i;
         if (rise) begin
            wprev_q <= wclk_s_i;
            cnt_q   <= cnt_n;
            if (wedge) begin
               fmt_q   <= fmt_i;
               armed_q <= 1'b1;
            end
            if (chg)         left_ok_q <= 1'b0;
            else if (done_o) left_ok_q <= done_left_o;
         end
      end
   end

endmodule

// File: rtl/tlrx_lane.sv
module tlrx_lane #(
   parameter int unsigned W = 24
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         sd_i,
   input  logic         shift_i,
   input  logic         take_pre_i,
   input  logic         done_i,
   input  logic         done_left_i,
   input  logic         publish_i,
   output logic [W-1:0] left_o,
   output logic [W-1:0] right_o
);

   logic [W-1:0] sr_q, sr_n, word, hold_q;

   assign sr_n = shift_i ? {sr_q[W-2:0], sd_i} : sr_q;
   assign word = take_pre_i ? sr_q : sr_n;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q    <= '0;
         hold_q  <= '0;
         left_o  <= '0;
         right_o <= '0;
      end else begin
         sr_q <= sr_n;
         if (done_i && done_left_i) hold_q <= word;
         if (publish_i) begin
            left_o  <= hold_q;
            right_o <= word;
         end
      end
   end

endmodule

// File: rtl/tri_lane_audio_rx.sv
module tri_lane_audio_rx
   import tlrx_pkg::*;
#(
   parameter int unsigned LANES       = 3,
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        bit_clk_i,
   input  logic                        word_clk_i,
   input  logic [LANES-1:0]            sdata_i,
   input  logic [FMT_W-1:0]            fmt_i,
   output logic [LANES*2*WORD_W-1:0]   pcm_o,
   output logic                        valid_o
);

   localparam int unsigned SYNC_W = LANES + 2;

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [SYNC_W-1:0] sync_q;
   logic shift, take_pre, done, done_left, publish;

   tlrx_sync #(.N(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  ({sdata_i, word_clk_i, bit_clk_i}),
      .dout_o (sync_q)
   );

   tlrx_framer #(.W(WORD_W)) u_framer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bclk_s_i    (sync_q[0]),
      .wclk_s_i    (sync_q[1]),
      .fmt_i       (fmt_i),
      .shift_o     (shift),
      .take_pre_o  (take_pre),
      .done_o      (done),
      .done_left_o (done_left),
      .publish_o   (publish)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      tlrx_lane #(.W(WORD_W)) u_lane (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .sd_i        (sync_q[2+l]),
         .shift_i     (shift),
         .take_pre_i  (take_pre),
         .done_i      (done),
         .done_left_i (done_left),
         .publish_i   (publish),
         .left_o      (pcm_o[2*l*WORD_W +: WORD_W]),
         .right_o     (pcm_o[(2*l+1)*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_o <= 1'b0;
      else         valid_o <= publish;
   end

endmodule

// File: rtl/tri_lane_audio_rx_chk.sv
module tri_lane_audio_rx_chk #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OUT_W       = 144
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bit_clk_i,
   input logic             word_clk_i,
   input logic [OUT_W-1:0] pcm_o,
   input logic             valid_o
);

   localparam int unsigned LIM = SYNC_STAGES + 4;
   localparam int unsigned SW  = $clog2(LIM + 2);

   logic          bclk_q, wclk_q;
   logic [SW-1:0] since_rise;
   logic [1:0]    wedges;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q     <= 1'b0;
         wclk_q     <= 1'b0;
         since_rise <= SW'(LIM + 1);
         wedges     <= 2'd0;
      end else begin
         bclk_q <= bit_clk_i;
         wclk_q <= word_clk_i;
         if (bit_clk_i && !bclk_q)      since_rise <= '0;
         else if (since_rise <= SW'(LIM)) since_rise <= since_rise + SW'(1);
         if (valid_o)                   wedges <= {1'b0, word_clk_i ^ wclk_q};
         else if ((word_clk_i ^ wclk_q) && wedges != 2'd3) wedges <= wedges + 2'd1;
      end
   end

   // R1
   always @(negedge clk_i) begin
      if (!rst_ni) begin
         reset_idle_chk: assert (valid_o == 1'b0 && pcm_o == '0);
      end
   end

   // R2
   valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   // R2
   out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(pcm_o));

   // R2
   near_bit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> since_rise <= SW'(LIM));

   // R10
   two_halves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> wedges >= 2'd2);

endmodule

bind tri_lane_audio_rx tri_lane_audio_rx_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .OUT_W       (LANES*2*WORD_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bit_clk_i  (bit_clk_i),
   .word_clk_i (word_clk_i),
   .pcm_o      (pcm_o),
   .valid_o    (valid_o)
);

// File: tb/tri_lane_audio_rx_tb_top.sv
module tri_lane_audio_rx_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bclk = 1'b0;
   logic         wclk = 1'b0;
   logic [2:0]   sd = 3'b000;
   logic [2:0]   fmt = 3'd0;
   logic [143:0] pcm;
   logic         valid;

   int checks = 0;
   int fails  = 0;

   logic [143:0] exp_q[$];
   string        tag_q[$];

   // bench framing: 0 right-justified, 1 left-justified, 2 delayed
   int       bmode = 0;
   logic [2:0] carry = 3'b000;
   int       sw_at = -1;
   logic [2:0] sw_code = 3'd0;

   always #5 clk = ~clk;

   tri_lane_audio_rx dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bit_clk_i  (bclk),
      .word_clk_i (wclk),
      .sdata_i    (sd),
      .fmt_i      (fmt),
      .pcm_o      (pcm),
      .valid_o    (valid)
   );

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic pick(input logic [23:0] w, input int i, input int nb, input int l);
      int pad;
      pad = nb - 24;
      if (bmode == 1) return (i < 24) ? w[23-i] : logic'(i % 2);
      if (bmode == 2) begin
         if (i == 0) return carry[l];
         return (i - 1 < 24) ? w[23-(i-1)] : logic'(i % 2);
      end
      return (i < pad) ? logic'((i + 1) % 2) : w[23-(i-pad)];
   endfunction

   task automatic drive_bit(input logic lvl, input logic [2:0] b);
      @(negedge clk);
      bclk = 1'b0;
      wclk = lvl;
      sd   = b;
      repeat (3) @(negedge clk);
      @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_half(input logic lvl, input logic [71:0] words, input int nb);
      for (int i = 0; i < nb; i++) begin
         logic [2:0] b;
         if (sw_at == i) fmt = sw_code;
         for (int l = 0; l < 3; l++) b[l] = pick(words[l*24 +: 24], i, nb, l);
         drive_bit(lvl, b);
      end
      if (bmode == 2) begin
         for (int l = 0; l < 3; l++) carry[l] = (nb == 24) ? words[l*24] : 1'b1;
      end
   endtask

   task automatic send_frame(input int nb, input bit expect_out, input string tag);
      logic [71:0]  lw, rw;
      logic [143:0] e;
      logic         llvl;
      for (int l = 0; l < 3; l++) begin
         lw[l*24 +: 24] = 24'($urandom);
         rw[l*24 +: 24] = 24'($urandom);
         e[2*l*24 +: 24]     = lw[l*24 +: 24];
         e[(2*l+1)*24 +: 24] = rw[l*24 +: 24];
      end
      if (expect_out) begin
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      llvl = (bmode == 2) ? 1'b0 : 1'b1;
      send_half(llvl, lw, nb);
      sw_at = -1;
      send_half(~llvl, rw, nb);
   endtask

   task automatic section(input logic [2:0] code, input int nb, input int nfr, input string tag);
      logic llvl;
      fmt   = code;
      bmode = (code == 3'd1) ? 1 : (code == 3'd2) ? 2 : 0;
      llvl  = (bmode == 2) ? 1'b0 : 1'b1;
      send_half(~llvl, 72'd0, nb);
      for (int f = 0; f < nfr; f++) send_frame(nb, 1'b1, tag);
   endtask

   task automatic tail(input int nb);
      send_half((bmode == 2) ? 1'b0 : 1'b1, 72'd0, nb);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected frame: actual %h expected none", pcm);
         end else begin
            logic [143:0] e;
            string        t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (pcm !== e) begin
               fails++;
               $display("FAIL R2/R3/%s frame: actual %h expected %h", t, pcm, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state while held
      checks++;
      if (valid !== 1'b0 || pcm !== '0) begin
         fails++;
         $display("FAIL R1 in reset: actual %b/%h expected 0/0", valid, pcm);
      end
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      checks++;
      if (valid !== 1'b0 || pcm !== '0) begin
         fails++;
         $display("FAIL R1 after reset: actual %b/%h expected 0/0", valid, pcm);
      end

      section(3'd0, 32, 3, "R4/R7 rj64");
      tail(32);
      section(3'd1, 24, 3, "R5/R7 lj48");
      tail(24);
      section(3'd2, 24, 3, "R6/R7 dly48");
      tail(24);
      section(3'd5, 24, 3, "R8 alias48");
      tail(24);
      section(3'd1, 32, 3, "R5 lj64");
      // R9: code switched mid left half, this frame must vanish
      sw_at   = 16;
      sw_code = 3'd0;
      send_frame(32, 1'b0, "R9");
      tail(32);
      section(3'd2, 32, 3, "R6/R9 dly64");
      tail(32);
      repeat (40) @(negedge clk);

      // R9/R10: every expected frame seen, no dropped frame leaked
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R9/R10 missing frames: actual %0d pending expected 0", exp_q.size());
      end
      report();
      $finish;
   end

endmodule